// File: doc/BRIEF.md
# Selectable-Rate Host Serial Port

This block is a full-duplex asynchronous serial port that lets an embedded peripheral controller act as the data-terminal side of a link to a host. The local logic hands it bytes to send through a valid/ready pair and takes received bytes from a one-byte holding register through a second valid/ready pair. Every character is 8 data bits with no parity, sent least significant bit first between a low start bit and a high stop level. The line idles high.

A 3-bit code picks one of eight line rates. The divisor for each rate is worked out at elaboration from the system clock frequency parameter. The selected divisor is taken up only while the transmitter is idle, so a frame in progress keeps its rate. The receiver oversamples at sixteen times the bit rate, confirms a start bit at its midpoint and reads each later bit at mid-bit. When the stop level is read low it flags a framing error and still delivers the byte.

An optional hardware flow-control mode gates the transmitter with a clear-to-send input. In this mode each frame also carries a second stop bit. The request-to-send output reports whether the receive holding register has room.

Top module: `hostSerialPort`

## Requirements
- R1: After reset txLine is high, txReady is high with flow control off, rxValid and frameErr are low, and rtsOut is high.
- R2: rateSel codes 0 to 7 select 2400, 4800, 9600, 19200, 38400, 57600, 115200 and 230400 bit/s. One bit lasts 16*floor(CLK_HZ/(16*rate)) clock cycles, measured from the clock edge that accepts the byte.
- R3: A transmitted frame is one low start bit, then txData bit 0 through bit 7, then high stop level. txReady returns high exactly 10 bit times after acceptance with flowEn low and 11 bit times after with flowEn high.
- R4: With flowEn high and ctsIn low, txReady stays low, no byte is accepted and txLine stays high.
- R5: If ctsIn drops while a frame is being sent, that frame still completes unchanged.
- R6: A change of rateSel while a frame is being sent does not alter the bit time of that frame.
- R7: A received byte appears on rxData with rxValid high and is held unchanged until a cycle with rxValid and rxReady both high. rxValid is low in the cycle after that.
- R8: A low level on rxIn shorter than half a bit time produces no byte, and the receiver still accepts the next valid frame.
- R9: A frame whose stop level is read low produces exactly one single-cycle frameErr pulse, and its byte is still delivered on rxData.
- R10: rtsOut is high exactly while the receive holding register is empty. While the register is full, a newly received byte is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rateSel | input | 3 | Line-rate code, 0 = 2400 up to 7 = 230400 bit/s |
| flowEn | input | 1 | Hardware flow control enable (CTS gate plus second stop bit) |
| txValid | input | 1 | Byte offered for transmission |
| txReady | output | 1 | Transmitter will accept a byte this cycle |
| txData | input | 8 | Byte to transmit |
| txLine | output | 1 | Serial transmit line, idle high |
| ctsIn | input | 1 | Clear to send, high allows a new frame |
| rtsOut | output | 1 | Request to send, high while the receive register is empty |
| rxIn | input | 1 | Serial receive line, idle high |
| rxValid | output | 1 | Receive holding register full |
| rxReady | input | 1 | Local logic takes the held byte |
| rxData | output | 8 | Received byte |
| frameErr | output | 1 | One-cycle pulse when a stop level is read low |

## Verification
The transmitter is swept over all eight rate codes, each with a different data byte. Reading the line at every mid-bit position separates a wrong divisor, a wrong bit order and a missing stop level. Frames with flow control on are checked for txReady going high at exactly eleven bit times, and that distinguishes one stop bit from two. Further frames drop clear-to-send or flip the rate code part way through, to show that a started frame is never altered. On the receive side, bytes arrive at two rates, a short low glitch is sent before a valid frame, and a frame with a low stop level is sent. Together these separate correct sampling from a glitch wrongly taken as a start bit, and a delivered framing error from a dropped byte.

// File: rtl/hspPkg.sv
package hspPkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RATE_CODES = 8;
  localparam int OVERSAMPLE = 16;
  localparam int DATA_BITS  = 8;

  typedef enum logic [1:0] {
    LINE_IDLE,
    LINE_START,
    LINE_DATA,
    LINE_STOP
  } lineState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rateLoad;
    logic txLoad;
    logic txShift;
    logic rxRestart;
    logic rxShift;
    logic rxCapture;
  } strobe_t;

  function automatic int unsigned baudOf(input int unsigned code);
    if (code < 5) return 32'd2400 << code;
    return 32'd57600 << (code - 5);
  endfunction

  function automatic int unsigned divisorOf(input int unsigned clkHz, input int unsigned code);
    int unsigned d;
    d = clkHz / (baudOf(code) * OVERSAMPLE);
    if (d == 0) d = 1;
    return d;
  endfunction
endpackage

// File: rtl/hspTick.sv
module hspTick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hspDatapath.sv
module hspDatapath import hspPkg::*; #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int          DIV_W  = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [2:0]           rateSel,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 rxIn,
  input  logic                 ctsIn,
  input  logic                 rxReady,
  output logic                 txLine,
  output logic                 txTick,
  output logic                 rxTick,
  output logic                 rxBit,
  output logic                 rxFall,
  output logic                 ctsSync,
  output logic                 rxFull,
  output logic [DATA_BITS-1:0] rxHold
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DIV_W-1:0]     divTable [RATE_CODES];
  logic [DIV_W-1:0]     divReg;
  logic [DATA_BITS-1:0] txShreg;
  logic [DATA_BITS-1:0] rxShreg;
  logic [1:0]           rxSyncQ;
  logic [1:0]           ctsQ;
  logic                 rxPrev;

  for (genvar g = 0; g < RATE_CODES; g++) begin : gDiv
    assign divTable[g] = DIV_W'(divisorOf(CLK_HZ, g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divReg <= divTable[0];
    else if (strobe.rateLoad) divReg <= divTable[rateSel];
  end

  hspTick #(.DIV_W(DIV_W)) u_txTick (
    .clk(clk), .rstN(rstN), .restart(strobe.txLoad), .div(divReg), .tick(txTick)
  );

  hspTick #(.DIV_W(DIV_W)) u_rxTick (
    .clk(clk), .rstN(rstN), .restart(strobe.rxRestart), .div(divReg), .tick(rxTick)
  );

  // transmit shifter: ones fill in behind the data to form the stop level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLine  <= 1'b1;
      txShreg <= '1;
    end else if (strobe.txLoad) begin
      txLine  <= 1'b0;
      txShreg <= txData;
    end else if (strobe.txShift) begin
      txLine  <= txShreg[0];
      txShreg <= {1'b1, txShreg[DATA_BITS-1:1]};
    end
  end

  // input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSyncQ <= '1;
      rxPrev  <= 1'b1;
      ctsQ    <= '0;
    end else begin
      rxSyncQ <= {rxSyncQ[0], rxIn};
      rxPrev  <= rxSyncQ[1];
      ctsQ    <= {ctsQ[0], ctsIn};
    end
  end

  assign rxBit   = rxSyncQ[1];
  assign rxFall  = rxPrev && !rxSyncQ[1];
  assign ctsSync = ctsQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxShreg <= '0;
    else if (strobe.rxShift) rxShreg <= {rxBit, rxShreg[DATA_BITS-1:1]};
  end

  // holding register: a byte arriving while full is discarded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxHold <= '0;
    end else if (strobe.rxCapture && !rxFull) begin
      rxFull <= 1'b1;
      rxHold <= rxShreg;
    end else if (rxFull && rxReady) begin
      rxFull <= 1'b0;
    end
  end
endmodule

// File: rtl/hspCtrl.sv
module hspCtrl import hspPkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    txValid,
  input  logic    flowEn,
  input  logic    ctsSync,
  input  logic    txTick,
  input  logic    rxTick,
  input  logic    rxBit,
  input  logic    rxFall,
  output strobe_t strobe,
  output logic    txReady,
  output logic    frameErr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVERSAMPLE / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

  lineState_t       txState, rxState;
  logic [SUB_W-1:0] txSub, rxSub;
  logic [IDX_W-1:0] txBitIdx, rxBitIdx;
  logic             txExtraStop;
  logic             txBitEnd, rxBitEnd;

  assign txReady  = (txState == LINE_IDLE) && (!flowEn || ctsSync);
  assign txBitEnd = txTick && (txSub == SUB_LAST);
  assign rxBitEnd = rxTick && (rxSub == SUB_LAST);

  always_comb begin
    strobe           = '0;
    strobe.rateLoad  = (txState == LINE_IDLE);
    strobe.txLoad    = txValid && txReady;
    strobe.txShift   = txBitEnd && (txState == LINE_START || txState == LINE_DATA);
    strobe.rxRestart = (rxState == LINE_IDLE) && rxFall;
    strobe.rxShift   = rxBitEnd && (rxState == LINE_DATA);
    strobe.rxCapture = rxBitEnd && (rxState == LINE_STOP);
  end

  // transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState     <= LINE_IDLE;
      txSub       <= '0;
      txBitIdx    <= '0;
      txExtraStop <= 1'b0;
    end else if (strobe.txLoad) begin
      txState     <= LINE_START;
      txSub       <= '0;
      txBitIdx    <= '0;
      txExtraStop <= flowEn;
    end else if (txTick && txState != LINE_IDLE) begin
      txSub <= txSub + 1'b1;
      if (txSub == SUB_LAST) begin
        case (txState)
          LINE_START: txState <= LINE_DATA;
          LINE_DATA: begin
            txBitIdx <= txBitIdx + 1'b1;
            if (txBitIdx == IDX_LAST) txState <= LINE_STOP;
          end
          LINE_STOP: begin
            if (txExtraStop) txExtraStop <= 1'b0;
            else             txState     <= LINE_IDLE;
          end
          default: txState <= LINE_IDLE;
        endcase
      end
    end
  end

  // receive sequencer: confirm start at mid-bit, then sample every 16 ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= LINE_IDLE;
      rxSub    <= '0;
      rxBitIdx <= '0;
    end else begin
      case (rxState)
        LINE_IDLE: begin
          if (rxFall) begin
            rxState <= LINE_START;
            rxSub   <= '0;
          end
        end
        LINE_START: begin
          if (rxTick) begin
            rxSub <= rxSub + 1'b1;
            if (rxSub == SUB_MID) begin
              rxSub    <= '0;
              rxBitIdx <= '0;
              rxState  <= rxBit ? LINE_IDLE : LINE_DATA;
            end
          end
        end
        LINE_DATA: begin
          if (rxTick) begin
            rxSub <= rxSub + 1'b1;
            if (rxSub == SUB_LAST) begin
              rxBitIdx <= rxBitIdx + 1'b1;
              if (rxBitIdx == IDX_LAST) rxState <= LINE_STOP;
            end
          end
        end
        default: begin
          if (rxTick) begin
            rxSub <= rxSub + 1'b1;
            if (rxSub == SUB_LAST) rxState <= LINE_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameErr <= 1'b0;
    else       frameErr <= strobe.rxCapture && !rxBit;
  end
endmodule

// File: rtl/hostSerialPort.sv
module hostSerialPort import hspPkg::*; #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] rateSel,
  input  logic       flowEn,
  input  logic       txValid,
  output logic       txReady,
  input  logic [7:0] txData,
  output logic       txLine,
  input  logic       ctsIn,
  output logic       rtsOut,
  input  logic       rxIn,
  output logic       rxValid,
  input  logic       rxReady,
  output logic [7:0] rxData,
  output logic       frameErr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIV_W = $clog2(divisorOf(CLK_HZ, 0) + 1);

  strobe_t strobe;
  logic    txTick, rxTick, rxBit, rxFall, ctsSync, rxFull;

  hspCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .flowEn(flowEn), .ctsSync(ctsSync),
    .txTick(txTick), .rxTick(rxTick), .rxBit(rxBit), .rxFall(rxFall),
    .strobe(strobe), .txReady(txReady), .frameErr(frameErr)
  );

  hspDatapath #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rateSel(rateSel), .txData(txData),
    .rxIn(rxIn), .ctsIn(ctsIn), .rxReady(rxReady), .txLine(txLine),
    .txTick(txTick), .rxTick(rxTick), .rxBit(rxBit), .rxFall(rxFall),
    .ctsSync(ctsSync), .rxFull(rxFull), .rxHold(rxData)
  );

  assign rxValid = rxFull;
  assign rtsOut  = !rxFull;
endmodule

// File: rtl/hspChecker.sv
module hspChecker (
  input logic       clk,
  input logic       rstN,
  input logic       txValid,
  input logic       txReady,
  input logic       txLine,
  input logic       rxValid,
  input logic       rxReady,
  input logic [7:0] rxData,
  input logic       frameErr
);
  timeunit 1ns;
  timeprecision 1ps;

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  assert_rx_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  assert_ferr_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  assert_ferr_delivered_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> rxValid);
endmodule

bind hostSerialPort hspChecker u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady), .txLine(txLine),
  .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .frameErr(frameErr)
);

// File: tb/hostSerialPort_tb.sv
module hostSerialPort_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CLK_HZ = 7_372_800;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] rateSel = 3'd7;
  logic       flowEn = 1'b0;
  logic       txValid = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       ctsIn = 1'b1;
  logic       rxIn = 1'b1;
  logic       rxReady = 1'b0;
  logic       txReady, txLine, rtsOut, rxValid, frameErr;
  logic [7:0] rxData;

  int checks = 0;
  int errors = 0;
  int ferrSeen = 0;

  hostSerialPort #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .flowEn(flowEn), .txValid(txValid),
    .txReady(txReady), .txData(txData), .txLine(txLine), .ctsIn(ctsIn), .rtsOut(rtsOut),
    .rxIn(rxIn), .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .frameErr(frameErr)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rstN && frameErr) ferrSeen++;

  function automatic int bitCycles(input int code);
    int rate;
    rate = (code < 5) ? (2400 << code) : (57600 << (code - 5));
    return 16 * (int'(CLK_HZ) / (16 * rate));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one transmitted frame, read at every mid-bit
  task automatic txFrame(input int code, input bit flow, input logic [7:0] d,
                         input int ctsDropAt, input int rateFlipAt, input string req);
    int  b;
    int  nb;
    logic expBit;
    b  = bitCycles(code);
    nb = flow ? 11 : 10;
    @(negedge clk);
    rateSel = 3'(code);
    flowEn  = flow;
    ctsIn   = 1'b1;
    repeat (4) @(negedge clk);
    chk(txReady == 1'b1, {req, " ready before frame"}, int'(txReady), 1);
    txValid = 1'b1;
    txData  = d;
    @(posedge clk);
    for (int t = 0; t < nb * b; t++) begin
      @(negedge clk);
      if (t == 0) txValid = 1'b0;
      if (t == ctsDropAt) ctsIn = 1'b0;
      if (t == rateFlipAt) rateSel = ~rateSel;
      if (t % b == b / 2) begin
        int k;
        k = t / b;
        expBit = (k == 0) ? 1'b0 : (k <= 8) ? d[k-1] : 1'b1;
        chk(txLine == expBit, {req, " line bit"}, int'(txLine), int'(expBit));
      end
      if (t == nb * b - 1)
        chk(txReady == 1'b0, {req, " busy at last cycle R3"}, int'(txReady), 0);
    end
    @(negedge clk);
    chk(txReady == (ctsDropAt < 0), {req, " ready after frame R3"}, int'(txReady),
        int'(ctsDropAt < 0));
    ctsIn = 1'b1;
  endtask

  // drive one frame onto rxIn, then read it out
  task automatic rxFrame(input int code, input logic [7:0] d, input bit stopBit,
                         input string req);
    int b;
    int f0;
    b = bitCycles(code);
    @(negedge clk);
    rateSel = 3'(code);
    flowEn  = 1'b0;
    repeat (4) @(negedge clk);
    f0 = ferrSeen;
    for (int k = 0; k < 10; k++) begin
      rxIn = (k == 0) ? 1'b0 : (k <= 8) ? d[k-1] : stopBit;
      repeat (b) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (b) @(negedge clk);
    chk(rxValid == 1'b1, {req, " valid R7"}, int'(rxValid), 1);
    chk(rxData == d, {req, " data R7"}, int'(rxData), int'(d));
    chk(rtsOut == 1'b0, {req, " rts low while full R10"}, int'(rtsOut), 0);
    chk(ferrSeen - f0 == (stopBit ? 0 : 1), {req, " frameErr pulses R9"}, ferrSeen - f0,
        stopBit ? 0 : 1);
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
    chk(rxValid == 1'b0, {req, " released R7"}, int'(rxValid), 0);
    chk(rtsOut == 1'b1, {req, " rts high when empty R10"}, int'(rtsOut), 1);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit blockOk;
    int b7;
    b7 = bitCycles(7);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txLine == 1'b1,   "R1 txLine",   int'(txLine), 1);
    chk(txReady == 1'b1,  "R1 txReady",  int'(txReady), 1);
    chk(rxValid == 1'b0,  "R1 rxValid",  int'(rxValid), 0);
    chk(frameErr == 1'b0, "R1 frameErr", int'(frameErr), 0);
    chk(rtsOut == 1'b1,   "R1 rtsOut",   int'(rtsOut), 1);

    // R2 R3: every rate code, one stop bit
    for (int code = 0; code < 8; code++)
      txFrame(code, 1'b0, 8'(8'h5A + code * 8'h29), -1, -1, "R2 sweep");

    // R3: flow control adds a second stop bit
    txFrame(7, 1'b1, 8'hC3, -1, -1, "R3 two stops");
    txFrame(7, 1'b1, 8'h01, -1, -1, "R3 two stops");

    // R4: clear-to-send low blocks a new frame
    @(negedge clk);
    flowEn  = 1'b1;
    ctsIn   = 1'b0;
    repeat (4) @(negedge clk);
    txValid = 1'b1;
    txData  = 8'hFF;
    blockOk = 1'b1;
    for (int t = 0; t < 64; t++) begin
      @(negedge clk);
      if (txReady || !txLine) blockOk = 1'b0;
    end
    chk(blockOk, "R4 blocked", int'(blockOk), 1);
    txValid = 1'b0;
    @(negedge clk);
    ctsIn = 1'b1;
    repeat (4) @(negedge clk);
    chk(txLine == 1'b1, "R4 no frame sent", int'(txLine), 1);

    // R5: drop CTS mid frame
    txFrame(7, 1'b1, 8'h96, 4 * b7, -1, "R5 cts drop");
    // R6: flip the rate code mid frame
    txFrame(6, 1'b0, 8'h3C, -1, 3 * bitCycles(6), "R6 rate flip");

    // receive side
    rxFrame(7, 8'hA7, 1'b1, "R7 rx fast");
    rxFrame(5, 8'h58, 1'b1, "R7 rx slower");

    // R8: short glitch rejected
    @(negedge clk);
    rateSel = 3'd7;
    repeat (4) @(negedge clk);
    rxIn = 1'b0;
    repeat (b7 / 4) @(negedge clk);
    rxIn = 1'b1;
    repeat (2 * b7) @(negedge clk);
    chk(rxValid == 1'b0, "R8 glitch gives no byte", int'(rxValid), 0);
    rxFrame(7, 8'h3B, 1'b1, "R8 after glitch");

    // R9: framing error still delivers
    rxFrame(7, 8'h6E, 1'b0, "R9 bad stop");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule